// File: doc/BRIEF.md
# Fused multiply-add significand core

This block is the exact arithmetic heart of a single-precision fused multiply-add. It takes two factors and an addend that have already been unpacked: a sign, an unbiased signed exponent and a 24-bit significand whose leading one is set. Subnormal inputs are assumed normalized before they arrive. A control input can negate the product, and a rounding-mode input sets the sign of an exactly cancelled result. Nothing is rounded until the final addition has been made.

The product is formed exactly and placed in a 64-bit working word with its leading one moved to bit 62. The addend is placed the same way. The operand with the smaller exponent is shifted right by the exponent gap, and every bit that drops off the end is kept as a sticky bit. The two words are then added or subtracted, and the result is normalized back so that its leading one sits at bit 62. The result is reduced to a 27-bit significand: 24 bits followed by guard, round and sticky. A later rounding and packing stage uses this significand. Results are registered, so each one appears one cycle after its input.

Top module: `fma_align_norm`

## Requirements
- R1: The product sign is fa_sign XOR fb_sign, inverted when neg_prod is 1. The product exponent is fa_exp + fb_exp, plus one when the exact significand product is 2.0 or more.
- R2: When ad_zero is 1 the result is the product alone. ad_sign, ad_exp and ad_sig have no effect on it.
- R3: The operand with the smaller exponent is shifted right by the exponent difference, and every bit shifted out is ORed into the word's bit 0. A gap of 64 or more leaves only that sticky bit.
- R4: When the product sign and the addend sign match, the magnitudes are added. A carry past the leading position shifts the sum right by one with sticky retention and raises the exponent by one.
- R5: When the signs differ, the smaller magnitude is subtracted from the larger, and the result takes the sign of the larger.
- R6: An exact cancellation gives res_sig = 0 and res_exp = 0. res_sign is 1 only when rmode = 2'b11 (toward minus infinity); the other codes are 00 nearest, 01 toward zero and 10 toward plus infinity.
- R7: Every nonzero result is normalized so that res_sig[26] = 1. The exponent drops by one for each left shift needed after a subtraction.
- R8: res_sig[26:3] holds the 24 leading significand bits and res_sig[2:1] holds guard and round. res_sig[0] is the OR of all lower exact bits of the result, so res_sig × 2^(res_exp−26) equals the exact value truncated with sticky.
- R9: out_valid is 1 exactly one cycle after in_valid was 1, with that input's result on the outputs. Reset clears out_valid and the result registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands present this cycle |
| neg_prod | input | 1 | Negate the product before the addition |
| rmode | input | 2 | Rounding mode, used only for the sign of a cancelled zero |
| fa_sign | input | 1 | First factor sign |
| fa_exp | input | EXP_W (10) | First factor unbiased exponent, signed |
| fa_sig | input | MAN_W (24) | First factor significand, leading one set |
| fb_sign | input | 1 | Second factor sign |
| fb_exp | input | EXP_W (10) | Second factor unbiased exponent, signed |
| fb_sig | input | MAN_W (24) | Second factor significand, leading one set |
| ad_sign | input | 1 | Addend sign |
| ad_exp | input | EXP_W (10) | Addend unbiased exponent, signed |
| ad_sig | input | MAN_W (24) | Addend significand, leading one set |
| ad_zero | input | 1 | Addend is zero; bypass the addition |
| out_valid | output | 1 | Result registers hold a new result |
| res_sign | output | 1 | Result sign |
| res_exp | output | EXP_W+2 (12) | Result exponent, signed |
| res_sig | output | MAN_W+3 (27) | Result significand with guard, round, sticky |

## Verification
The bench compares every result against an exact big-integer model of the sum. It targets the cases most likely to hide an error. Product carries at 1.5 × 1.5 check the exponent bump; if that step were dropped, the exponent would come out one low. Exponent gaps of 70 to 100 bits show whether the sticky bit survives. A plain shift would lose it, so res_sig[0] would read 0 and the low bits would be wrong after a subtraction.

Exact cancellation is tried under each rounding mode and with the negate control. A wrong zero sign, or a leftover exponent, shows up directly at the outputs. Near-cancellation of 1 + 2^-23 against 1 checks that the exponent falls by one per normalizing shift. A zeroed addend fed with garbage fields checks that the bypass ignores them; a design that still added the addend would return a shifted value.

// File: rtl/fma_aan_pkg.sv
package fma_aan_pkg;
   typedef enum logic [1:0] {
      RM_NEAR = 2'b00,
      RM_ZERO = 2'b01,
      RM_UP   = 2'b10,
      RM_DOWN = 2'b11
   } fma_rm_e;
endpackage

// File: rtl/fma_sticky_shr.sv
// Right shift that folds every discarded bit into bit 0.
module fma_sticky_shr #(
   parameter int W  = 64,
   parameter int AW = 12
) (
   input  logic [W-1:0]  din,
   input  logic [AW-1:0] amt,
   output logic [W-1:0]  dout
);
   logic [W-1:0] kept;
   logic [W-1:0] lost_mask;
   logic         lost_any;

   always_comb begin
      kept      = din >> amt;
      lost_mask = ~({W{1'b1}} << amt);
      lost_any  = |(din & lost_mask);
      dout      = kept | {{(W-1){1'b0}}, lost_any};
   end
endmodule

// File: rtl/fma_prod_stage.sv
// Exact significand product, placed with its leading one at bit WORK_W-2.
module fma_prod_stage #(
   parameter int MAN_W  = 24,
   parameter int WORK_W = 64,
   parameter int XW     = 12
) (
   input  logic                 sa,
   input  logic                 sb,
   input  logic                 neg,
   input  logic signed [XW-1:0] ea,
   input  logic signed [XW-1:0] eb,
   input  logic [MAN_W-1:0]     ma,
   input  logic [MAN_W-1:0]     mb,
   output logic                 p_sign,
   output logic signed [XW-1:0] p_exp,
   output logic [WORK_W-1:0]    p_word
);
   localparam int PROD_W   = 2 * MAN_W;
   localparam int PROD_SHL = WORK_W - PROD_W;

   logic [PROD_W-1:0] prod;
   logic [WORK_W-1:0] raw;
   logic              over;

   always_comb begin
      prod   = PROD_W'(ma) * PROD_W'(mb);
      raw    = WORK_W'(prod) << PROD_SHL;
      over   = raw[WORK_W-1];
      // bit 0 of raw is zero because PROD_SHL >= 1, so nothing is lost here
      p_word = over ? (raw >> 1) : raw;
      p_exp  = ea + eb + (over ? XW'(1) : XW'(0));
      p_sign = sa ^ sb ^ neg;
   end
endmodule

// File: rtl/fma_align_add.sv
// Exponent alignment with sticky shifts, then signed-magnitude add/subtract.
module fma_align_add #(
   parameter int WORK_W = 64,
   parameter int XW     = 12
) (
   input  logic                 p_sign,
   input  logic signed [XW-1:0] p_exp,
   input  logic [WORK_W-1:0]    p_word,
   input  logic                 z_sign,
   input  logic signed [XW-1:0] z_exp,
   input  logic [WORK_W-1:0]    z_word,
   output logic [WORK_W-1:0]    p_al,
   output logic [WORK_W-1:0]    z_al,
   output logic                 s_sign,
   output logic signed [XW-1:0] s_exp,
   output logic [WORK_W-1:0]    s_word,
   output logic                 s_zero
);
   logic              z_bigger;
   logic [XW-1:0]     amt_p;
   logic [XW-1:0]     amt_z;
   logic signed [XW-1:0] com_exp;
   logic [WORK_W-1:0] sum_raw;
   logic [WORK_W-1:0] sum_fix;
   logic [WORK_W-1:0] dif;

   always_comb begin
      z_bigger = (z_exp > p_exp);
      amt_p    = z_bigger ? XW'(z_exp - p_exp) : '0;
      amt_z    = z_bigger ? '0 : XW'(p_exp - z_exp);
      com_exp  = z_bigger ? z_exp : p_exp;
   end

   fma_sticky_shr #(.W(WORK_W), .AW(XW)) u_shp (.din(p_word), .amt(amt_p), .dout(p_al));
   fma_sticky_shr #(.W(WORK_W), .AW(XW)) u_shz (.din(z_word), .amt(amt_z), .dout(z_al));

   assign sum_raw = p_al + z_al;

   fma_sticky_shr #(.W(WORK_W), .AW(1)) u_carry (
      .din(sum_raw), .amt(sum_raw[WORK_W-1]), .dout(sum_fix));

   always_comb begin
      dif    = '0;
      s_sign = z_sign;
      s_exp  = com_exp;
      s_word = '0;
      s_zero = 1'b0;
      if (p_sign == z_sign) begin
         s_word = sum_fix;
         s_exp  = com_exp + (sum_raw[WORK_W-1] ? XW'(1) : XW'(0));
      end else begin
         if (z_al >= p_al) begin
            dif    = z_al - p_al;
            s_sign = z_sign;
         end else begin
            dif    = p_al - z_al;
            s_sign = p_sign;
         end
         s_word = dif;
         s_zero = (dif == '0);
      end
   end
endmodule

// File: rtl/fma_norm.sv
// Left-normalizes a word so that its leading one sits at bit WORK_W-2.
module fma_norm #(
   parameter int WORK_W = 64,
   parameter int XW     = 12
) (
   input  logic [WORK_W-1:0]    w_in,
   input  logic signed [XW-1:0] e_in,
   output logic [WORK_W-1:0]    w_out,
   output logic signed [XW-1:0] e_out
);
   localparam int LEAD = WORK_W - 2;
   localparam int LZ_W = $clog2(WORK_W);

   logic [LZ_W-1:0] top_idx;
   logic [LZ_W-1:0] lz;

   always_comb begin
      top_idx = '0;
      for (int i = 0; i <= LEAD; i++) begin
         if (w_in[i]) top_idx = LZ_W'(i);
      end
      lz    = LZ_W'(LEAD) - top_idx;
      w_out = w_in << lz;
      e_out = e_in - XW'(lz);
   end
endmodule

// File: rtl/fma_align_norm.sv
module fma_align_norm
   import fma_aan_pkg::*;
#(
   parameter int EXP_W  = 10,
   parameter int MAN_W  = 24,
   parameter int WORK_W = 64,
   parameter int GRS_W  = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic                     neg_prod,
   input  logic [1:0]               rmode,
   input  logic                     fa_sign,
   input  logic [EXP_W-1:0]         fa_exp,
   input  logic [MAN_W-1:0]         fa_sig,
   input  logic                     fb_sign,
   input  logic [EXP_W-1:0]         fb_exp,
   input  logic [MAN_W-1:0]         fb_sig,
   input  logic                     ad_sign,
   input  logic [EXP_W-1:0]         ad_exp,
   input  logic [MAN_W-1:0]         ad_sig,
   input  logic                     ad_zero,
   output logic                     out_valid,
   output logic                     res_sign,
   output logic [EXP_W+1:0]         res_exp,
   output logic [MAN_W+GRS_W-1:0]   res_sig
);
   localparam int XW      = EXP_W + 2;
   localparam int OUT_W   = MAN_W + GRS_W;
   localparam int LEAD    = WORK_W - 2;
   localparam int ADD_SHL = LEAD - (MAN_W - 1);
   localparam int OUT_LO  = LEAD - OUT_W + 1;

   generate
      if (WORK_W < 2 * MAN_W + 2) begin : g_bad_work
         $error("fma_align_norm: WORK_W too narrow for the exact product");
      end
      if (OUT_LO < 1) begin : g_bad_out
         $error("fma_align_norm: output significand wider than working word");
      end
      if (EXP_W < 9) begin : g_bad_exp
         $error("fma_align_norm: EXP_W too narrow for intermediate exponents");
      end
   endgenerate

   logic signed [XW-1:0] ea_x, eb_x, ez_x;
   assign ea_x = {{(XW-EXP_W){fa_exp[EXP_W-1]}}, fa_exp};
   assign eb_x = {{(XW-EXP_W){fb_exp[EXP_W-1]}}, fb_exp};
   assign ez_x = {{(XW-EXP_W){ad_exp[EXP_W-1]}}, ad_exp};

   logic                 p_sign;
   logic signed [XW-1:0] p_exp;
   logic [WORK_W-1:0]    p_word;

   fma_prod_stage #(.MAN_W(MAN_W), .WORK_W(WORK_W), .XW(XW)) u_prod (
      .sa(fa_sign), .sb(fb_sign), .neg(neg_prod),
      .ea(ea_x), .eb(eb_x), .ma(fa_sig), .mb(fb_sig),
      .p_sign(p_sign), .p_exp(p_exp), .p_word(p_word));

   logic [WORK_W-1:0] z_word;
   assign z_word = WORK_W'(ad_sig) << ADD_SHL;

   logic [WORK_W-1:0]    p_al, z_al, s_word;
   logic                 s_sign, s_zero;
   logic signed [XW-1:0] s_exp;

   fma_align_add #(.WORK_W(WORK_W), .XW(XW)) u_add (
      .p_sign(p_sign), .p_exp(p_exp), .p_word(p_word),
      .z_sign(ad_sign), .z_exp(ez_x), .z_word(z_word),
      .p_al(p_al), .z_al(z_al),
      .s_sign(s_sign), .s_exp(s_exp), .s_word(s_word), .s_zero(s_zero));

   // Zero addend: the product bypasses the adder entirely
   logic                 m_sign, m_zero;
   logic signed [XW-1:0] m_exp;
   logic [WORK_W-1:0]    m_word;

   always_comb begin
      if (ad_zero) begin
         m_sign = p_sign;
         m_exp  = p_exp;
         m_word = p_word;
         m_zero = 1'b0;
      end else begin
         m_sign = s_sign;
         m_exp  = s_exp;
         m_word = s_word;
         m_zero = s_zero;
      end
   end

   logic [WORK_W-1:0]    n_word;
   logic signed [XW-1:0] n_exp;

   fma_norm #(.WORK_W(WORK_W), .XW(XW)) u_norm (
      .w_in(m_word), .e_in(m_exp), .w_out(n_word), .e_out(n_exp));

   logic [OUT_W-1:0] red_sig;
   always_comb begin
      red_sig    = n_word[LEAD -: OUT_W];
      red_sig[0] = red_sig[0] | (|n_word[OUT_LO-1:0]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         res_sign  <= 1'b0;
         res_exp   <= '0;
         res_sig   <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            if (m_zero) begin
               res_sign <= (fma_rm_e'(rmode) == RM_DOWN);
               res_exp  <= '0;
               res_sig  <= '0;
            end else begin
               res_sign <= m_sign;
               res_exp  <= n_exp;
               res_sig  <= red_sig;
            end
         end
      end
   end

   // R9
   valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   // R9
   valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   // R1
   prod_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && fa_sig[MAN_W-1] && fb_sig[MAN_W-1]) |-> (p_word[LEAD] && !p_word[WORK_W-1]));
   // R3
   align_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !ad_zero && ad_sig[MAN_W-1]) |-> ((z_al != '0) && (p_al != '0)));
   // R4
   add_nocarry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !m_zero) |-> !n_word[WORK_W-1]);
   // R7
   norm_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && (res_sig != '0)) |-> res_sig[OUT_W-1]);
   // R6
   cancel_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && (res_sig == '0)) |-> ((res_exp == '0) && (res_sign == ($past(rmode) == 2'b11))));
endmodule

// File: tb/fma_align_norm_tb.sv
`timescale 1ns/1ps
module fma_align_norm_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic        in_valid = 1'b0, neg_prod = 1'b0, ad_zero = 1'b0;
   logic [1:0]  rmode = 2'b00;
   logic        fa_sign = 1'b0, fb_sign = 1'b0, ad_sign = 1'b0;
   logic [9:0]  fa_exp = '0, fb_exp = '0, ad_exp = '0;
   logic [23:0] fa_sig = 24'h800000, fb_sig = 24'h800000, ad_sig = 24'h800000;
   logic        out_valid, res_sign;
   logic [11:0] res_exp;
   logic [26:0] res_sig;

   fma_align_norm dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .neg_prod(neg_prod), .rmode(rmode),
      .fa_sign(fa_sign), .fa_exp(fa_exp), .fa_sig(fa_sig),
      .fb_sign(fb_sign), .fb_exp(fb_exp), .fb_sig(fb_sig),
      .ad_sign(ad_sign), .ad_exp(ad_exp), .ad_sig(ad_sig), .ad_zero(ad_zero),
      .out_valid(out_valid), .res_sign(res_sign), .res_exp(res_exp), .res_sig(res_sig));

   typedef struct packed {
      logic        s;
      logic [11:0] e;
      logic [26:0] g;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];
   int    total = 0;
   int    bad   = 0;

   // Exact reference: both terms as integers over a common least-significant weight
   function automatic exp_t model(input bit sx, input bit sy, input bit sz, input bit ng,
                                  input int ex, input int ey, input int ez,
                                  input logic [23:0] mx, input logic [23:0] my,
                                  input logic [23:0] mz, input bit zz, input logic [1:0] rm);
      logic [319:0] pa, za, a, mask;
      logic [47:0]  p48;
      int           ep, ezl, emin, m;
      bit           ps, sg;
      exp_t         r;
      p48 = {24'b0, mx} * {24'b0, my};
      ps  = sx ^ sy ^ ng;
      ep  = ex + ey - 46;
      ezl = ez - 23;
      if (zz) begin
         emin = ep;
         a    = {272'b0, p48};
         sg   = ps;
      end else begin
         emin = (ep < ezl) ? ep : ezl;
         pa   = {272'b0, p48} << (ep - emin);
         za   = {296'b0, mz} << (ezl - emin);
         if (ps == sz) begin
            a = pa + za; sg = ps;
         end else if (pa > za) begin
            a = pa - za; sg = ps;
         end else begin
            a = za - pa; sg = sz;
         end
      end
      if (a == '0) begin
         r.s = (rm == 2'b11);
         r.e = '0;
         r.g = '0;
         return r;
      end
      m = 0;
      for (int i = 0; i < 320; i++) if (a[i]) m = i;
      r.s = sg;
      r.e = 12'(m + emin);
      if (m >= 26) begin
         mask = (320'd1 << (m - 26)) - 320'd1;
         r.g  = 27'(a >> (m - 26));
         r.g[0] = r.g[0] | (|(a & mask));
      end else begin
         r.g = 27'(a << (26 - m));
      end
      return r;
   endfunction

   task automatic drive(input bit sx, input bit sy, input bit sz, input bit ng,
                        input int ex, input int ey, input int ez,
                        input logic [23:0] mx, input logic [23:0] my, input logic [23:0] mz,
                        input bit zz, input logic [1:0] rm, input string tag);
      @(negedge clk);
      exp_q.push_back(model(sx, sy, sz, ng, ex, ey, ez, mx, my, mz, zz, rm));
      tag_q.push_back(tag);
      in_valid = 1'b1;
      fa_sign = sx; fb_sign = sy; ad_sign = sz; neg_prod = ng;
      fa_exp = 10'(ex); fb_exp = 10'(ey); ad_exp = 10'(ez);
      fa_sig = mx; fb_sig = my; ad_sig = mz; ad_zero = zz; rmode = rm;
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   // Monitor: pops the scoreboard whenever a result appears
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         total++;
         if (exp_q.size() == 0) begin
            bad++;
            $display("FAIL R9: result with no pending input (sig=%h)", res_sig);
         end else begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (res_sign !== e.s || res_exp !== e.e || res_sig !== e.g) begin
               bad++;
               $display("FAIL %s: got s=%0b e=%0d g=%h expected s=%0b e=%0d g=%h", t,
                        res_sign, $signed(res_exp), res_sig, e.s, $signed(e.e), e.g);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: run did not finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9 reset state
      total++;
      if (out_valid !== 1'b0 || res_sig !== '0) begin
         bad++;
         $display("FAIL R9: reset state valid=%0b sig=%h expected 0/0", out_valid, res_sig);
      end
      rst_n = 1'b1;
      @(negedge clk);
      total++;
      if (out_valid !== 1'b0) begin
         bad++;
         $display("FAIL R9: idle valid=%0b expected 0", out_valid);
      end

      // R1 R2: product only, carry 1.5*1.5, then negated
      drive(0, 0, 0, 0, 0, 0, 0, 24'hC00000, 24'hC00000, 24'h800000, 1, 2'b00, "R1 carry");
      drive(0, 1, 0, 1, 3, -5, 0, 24'hC00000, 24'hA00000, 24'h800000, 1, 2'b00, "R1 negate");
      // R2: garbage addend fields ignored
      drive(1, 0, 1, 0, 2, 2, 90, 24'h900000, 24'h800000, 24'h123456, 1, 2'b11, "R2 ignore");
      // R8: all-ones product, sticky below guard/round
      drive(0, 0, 0, 0, 0, 0, 0, 24'hFFFFFF, 24'hFFFFFF, 24'h800000, 1, 2'b00, "R8 sticky");
      // R4: addition with and without carry
      drive(0, 0, 0, 0, 0, 0, 0, 24'hC00000, 24'h800000, 24'hC00000, 0, 2'b00, "R4 carry");
      drive(1, 0, 1, 0, 4, 0, 1, 24'h800001, 24'h800000, 24'h812345, 0, 2'b00, "R4 nocarry");
      // R3: huge gaps, sticky only
      drive(0, 0, 0, 0, -30, -30, 40, 24'hFFFFFF, 24'hFFFFFF, 24'h800000, 0, 2'b00, "R3 add gap");
      drive(0, 0, 1, 0, 35, 35, 0, 24'h800000, 24'h800000, 24'hABCDEF, 0, 2'b00, "R3 sub gap");
      drive(1, 0, 0, 0, -40, -40, 10, 24'h800000, 24'h800000, 24'h800000, 0, 2'b00, "R3 sub gap2");
      // R5: larger magnitude decides the sign
      drive(0, 0, 1, 0, 0, 0, 1, 24'hC00000, 24'h800000, 24'h900000, 0, 2'b00, "R5 z larger");
      drive(0, 0, 0, 1, 1, 1, 0, 24'hC00000, 24'h800000, 24'h900000, 0, 2'b00, "R5 p larger");
      // R6: exact cancellation under each mode and via negate
      drive(0, 0, 1, 0, 0, 0, 0, 24'h800000, 24'h800000, 24'h800000, 0, 2'b00, "R6 near");
      drive(0, 0, 1, 0, 0, 0, 0, 24'h800000, 24'h800000, 24'h800000, 0, 2'b11, "R6 down");
      drive(1, 0, 0, 0, 5, -2, 3, 24'hC00000, 24'h800000, 24'hC00000, 0, 2'b10, "R6 up");
      drive(0, 0, 0, 1, 2, 2, 4, 24'h800000, 24'h800000, 24'h800000, 0, 2'b11, "R6 negate");
      // R7: deep cancellation
      drive(0, 0, 1, 0, 0, 0, 0, 24'h800001, 24'h800000, 24'h800000, 0, 2'b00, "R7 deep");
      drive(0, 0, 1, 0, 0, 0, 0, 24'h800001, 24'h800001, 24'h800000, 0, 2'b00, "R7 deep2");
      drive(1, 1, 0, 0, 0, 0, 1, 24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFE, 0, 2'b01, "R7 near");
      idle();

      for (int k = 0; k < 60; k++) begin
         int ex, ey, ez;
         ex = int'($urandom_range(60)) - 30;
         ey = int'($urandom_range(60)) - 30;
         ez = int'($urandom_range(60)) - 30;
         drive(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), ex, ey, ez,
               24'($urandom) | 24'h800000, 24'($urandom) | 24'h800000,
               24'($urandom) | 24'h800000, ($urandom_range(9) == 0), 2'($urandom),
               "R3 R4 R5 R7 R8 random");
      end
      idle();
      repeat (3) @(negedge clk);

      // R9 latency: one cycle, then idle
      drive(0, 0, 0, 0, 1, 1, 0, 24'h800000, 24'h800000, 24'h800000, 0, 2'b00, "R9 value");
      idle();
      total++;
      if (out_valid !== 1'b1) begin
         bad++;
         $display("FAIL R9: valid=%0b expected 1", out_valid);
      end
      @(negedge clk);
      total++;
      if (out_valid !== 1'b0) begin
         bad++;
         $display("FAIL R9: valid=%0b expected 0", out_valid);
      end
      repeat (2) @(negedge clk);
      total++;
      if (exp_q.size() != 0) begin
         bad++;
         $display("FAIL R9: %0d results missing, expected 0", exp_q.size());
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule